// File: doc/BRIEF.md
# Two-Source Interrupt Status Unit

This block keeps the interrupt state for a timer that has one compare source and one capture source. Each source owns one raw status bit and one enable (mask) bit. The raw bit is set by a hardware event pulse, and software can also force it through a set strobe. It is cleared by a clear strobe or by a side-effect access to that channel's own value register. The masked status is the per-bit AND of raw status and mask. A single interrupt line is raised while any masked bit is high.

Software reaches the block through already-decoded strobes. Each strobe comes with a 2-bit data word, in which bit 0 selects the compare source and bit 1 selects the capture source. There are strobes for the whole mask, for setting status, for clearing status, for setting mask bits and for clearing mask bits. Two further single-bit inputs carry the side-effect clears: a write of a new compare value, and a read of the captured value. All state sits in registers and changes at the rising clock edge that samples a strobe or event. Masked status and the interrupt line follow the registers combinationally.

Top module: `irq_stat_top`

## Requirements
- R1: After reset, raw status, mask, masked status and the interrupt line are all 0.
- R2: A compare event pulse (`cmp_evt`) sets raw bit 0, and a capture event pulse (`cap_evt`) sets raw bit 1, at the next rising edge.
- R3: With `stat_set_en` high, each 1 in `stat_set_data` sets the matching raw bit (bit 0 compare, bit 1 capture). Zero bits leave their raw bit unchanged.
- R4: With `stat_clr_en` high, each 1 in `stat_clr_data` clears the matching raw bit. Zero bits leave their raw bit unchanged.
- R5: `cmp_val_wr` clears raw bit 0 only, and `cap_val_rd` clears raw bit 1 only.
- R6: When an event or a status set targets a bit in the same cycle as any clear (explicit or side-effect), the bit ends up set.
- R7: `mask_wr_en` loads `mask_wr_data` into the mask. With `mask_set_en`, each 1 in `mask_set_data` sets that mask bit. With `mask_clr_en`, each 1 in `mask_clr_data` clears that mask bit. Zero data bits have no effect.
- R8: On one bit in one cycle, a mask set beats a mask clear, and a mask clear beats a whole-mask write.
- R9: `masked_stat` equals `mask & raw_stat`, and `irq` is the OR of `masked_stat`.
- R10: In a cycle with no event, strobe or side-effect clear, raw status and mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_evt | input | 1 | Compare event pulse |
| cap_evt | input | 1 | Capture event pulse |
| mask_wr_en | input | 1 | Whole-mask write strobe |
| mask_wr_data | input | 2 | Whole-mask write value |
| stat_set_en | input | 1 | Status set strobe |
| stat_set_data | input | 2 | Raw bits to set |
| stat_clr_en | input | 1 | Status clear strobe |
| stat_clr_data | input | 2 | Raw bits to clear |
| mask_set_en | input | 1 | Mask set strobe |
| mask_set_data | input | 2 | Mask bits to set |
| mask_clr_en | input | 1 | Mask clear strobe |
| mask_clr_data | input | 2 | Mask bits to clear |
| cmp_val_wr | input | 1 | Compare value written (clears raw bit 0) |
| cap_val_rd | input | 1 | Captured value read (clears raw bit 1) |
| raw_stat | output | 2 | Raw status |
| mask | output | 2 | Interrupt enable mask |
| masked_stat | output | 2 | Masked status |
| irq | output | 1 | Combined interrupt line |

## Verification
A wrong raw or mask bit appears on `raw_stat` or `mask` one edge after the stimulus that caused it. It appears on `masked_stat` and `irq` in the same cycle whenever the other operand bit is 1. A lost event or a wrong priority therefore shows at the ports after a single clock. The bench drives each collision case directly. It then sweeps several thousand cycles of mixed strobes and events against an arithmetic model, so that every priority combination on both lanes is reached.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_CMP = 0;
    localparam int SRC_CAP = 1;

    typedef struct packed {
        logic raw;
        logic en;
    } lane_state_t;
endpackage

// File: rtl/irq_stat_lane.sv
module irq_stat_lane
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic side_clr,
    input  logic en_wr,
    input  logic en_wr_bit,
    input  logic en_set,
    input  logic en_clr,
    output logic raw_q,
    output logic en_q
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // status: any set source beats any clear source
        if (hw_evt || sw_set)
            st_d.raw = 1'b1;
        else if (sw_clr || side_clr)
            st_d.raw = 1'b0;
        // mask: set > clear > whole write
        if (en_set)
            st_d.en = 1'b1;
        else if (en_clr)
            st_d.en = 1'b0;
        else if (en_wr)
            st_d.en = en_wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign raw_q = st_q.raw;
    assign en_q  = st_q.en;

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> raw_q);
    a_r4_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_evt && !sw_set) |=> !raw_q);
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_evt || sw_set) && (sw_clr || side_clr)) |=> raw_q);
    a_r8_mset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && en_clr) |=> en_q);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_evt && !sw_set && !sw_clr && !side_clr && !en_wr && !en_set && !en_clr)
        |=> ($stable(raw_q) && $stable(en_q)));
endmodule

// File: rtl/irq_stat_merge.sv
module irq_stat_merge #(
    parameter int N = 2
) (
    input  logic [N-1:0] raw_v,
    input  logic [N-1:0] en_v,
    output logic [N-1:0] masked_v,
    output logic         line
);
    always_comb begin
        masked_v = raw_v & en_v;
        line     = |masked_v;
    end
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
    import irq_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_evt,
    input  logic               cap_evt,
    input  logic               mask_wr_en,
    input  logic [NUM_SRC-1:0] mask_wr_data,
    input  logic               stat_set_en,
    input  logic [NUM_SRC-1:0] stat_set_data,
    input  logic               stat_clr_en,
    input  logic [NUM_SRC-1:0] stat_clr_data,
    input  logic               mask_set_en,
    input  logic [NUM_SRC-1:0] mask_set_data,
    input  logic               mask_clr_en,
    input  logic [NUM_SRC-1:0] mask_clr_data,
    input  logic               cmp_val_wr,
    input  logic               cap_val_rd,
    output logic [NUM_SRC-1:0] raw_stat,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] masked_stat,
    output logic               irq
);
    logic [NUM_SRC-1:0] evt_v, side_v;

    always_comb begin
        evt_v  = '0;
        side_v = '0;
        evt_v[SRC_CMP]  = cmp_evt;
        evt_v[SRC_CAP]  = cap_evt;
        side_v[SRC_CMP] = cmp_val_wr;
        side_v[SRC_CAP] = cap_val_rd;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        irq_stat_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_evt    (evt_v[g]),
            .sw_set    (stat_set_en & stat_set_data[g]),
            .sw_clr    (stat_clr_en & stat_clr_data[g]),
            .side_clr  (side_v[g]),
            .en_wr     (mask_wr_en),
            .en_wr_bit (mask_wr_data[g]),
            .en_set    (mask_set_en & mask_set_data[g]),
            .en_clr    (mask_clr_en & mask_clr_data[g]),
            .raw_q     (raw_stat[g]),
            .en_q      (mask[g])
        );
    end

    irq_stat_merge #(.N(NUM_SRC)) u_merge (
        .raw_v    (raw_stat),
        .en_v     (mask),
        .masked_v (masked_stat),
        .line     (irq)
    );

    a_r5_cmp_side_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val_wr && !cmp_evt && !(stat_set_en && stat_set_data[SRC_CMP])) |=> !raw_stat[SRC_CMP]);
    a_r5_cap_side_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_val_rd && !cap_evt && !(stat_set_en && stat_set_data[SRC_CAP])) |=> !raw_stat[SRC_CAP]);
    a_r9_irq_follows_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(raw_stat & mask)));
endmodule

// File: tb/tb_irq_stat_top.sv
module tb_irq_stat_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic cmp_evt, cap_evt, mask_wr_en, stat_set_en, stat_clr_en, mask_set_en, mask_clr_en;
    logic cmp_val_wr, cap_val_rd;
    logic [1:0] mask_wr_data, stat_set_data, stat_clr_data, mask_set_data, mask_clr_data;
    logic [1:0] raw_stat, mask, masked_stat;
    logic irq;

    irq_stat_top dut (
        .clk(clk), .rst_n(rst_n), .cmp_evt(cmp_evt), .cap_evt(cap_evt),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .stat_set_en(stat_set_en), .stat_set_data(stat_set_data),
        .stat_clr_en(stat_clr_en), .stat_clr_data(stat_clr_data),
        .mask_set_en(mask_set_en), .mask_set_data(mask_set_data),
        .mask_clr_en(mask_clr_en), .mask_clr_data(mask_clr_data),
        .cmp_val_wr(cmp_val_wr), .cap_val_rd(cap_val_rd),
        .raw_stat(raw_stat), .mask(mask), .masked_stat(masked_stat), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] exp_raw, exp_mask;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmp_evt = 0; cap_evt = 0; cmp_val_wr = 0; cap_val_rd = 0;
        mask_wr_en = 0; stat_set_en = 0; stat_clr_en = 0; mask_set_en = 0; mask_clr_en = 0;
        mask_wr_data = 0; stat_set_data = 0; stat_clr_data = 0; mask_set_data = 0; mask_clr_data = 0;
    endtask

    // Model from R2..R8, applied at the edge, then outputs compared.
    task automatic tick();
        logic [1:0] s, c, ms, mc;
        s  = {cap_evt, cmp_evt} | (stat_set_en ? stat_set_data : 2'b00);
        c  = (stat_clr_en ? stat_clr_data : 2'b00) | {cap_val_rd, cmp_val_wr};
        ms = mask_set_en ? mask_set_data : 2'b00;
        mc = mask_clr_en ? mask_clr_data : 2'b00;
        for (int b = 0; b < 2; b++) begin
            if (s[b]) exp_raw[b] = 1'b1;
            else if (c[b]) exp_raw[b] = 1'b0;
            if (ms[b]) exp_mask[b] = 1'b1;
            else if (mc[b]) exp_mask[b] = 1'b0;
            else if (mask_wr_en) exp_mask[b] = mask_wr_data[b];
        end
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check_all(string tag);
        chk({tag, " raw"}, raw_stat, exp_raw);
        chk({tag, " mask"}, mask, exp_mask);
        chk({tag, " R9 masked"}, masked_stat, exp_raw & exp_mask);
        chk({tag, " R9 irq"}, irq, |(exp_raw & exp_mask));
    endtask

    initial begin
        idle();
        exp_raw = 0; exp_mask = 0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        cmp_evt = 1; tick(); check_all("R2 cmp event");
        mask_set_en = 1; mask_set_data = 2'b11; tick(); check_all("R7 mask set both");
        cap_evt = 1; tick(); check_all("R2 cap event");
        stat_clr_en = 1; stat_clr_data = 2'b01; tick(); check_all("R4 clear bit0");
        stat_clr_en = 1; stat_clr_data = 2'b00; tick(); check_all("R4 clear zero data");
        stat_set_en = 1; stat_set_data = 2'b01; tick(); check_all("R3 set bit0");
        stat_set_en = 1; stat_set_data = 2'b00; tick(); check_all("R3 set zero data");
        cmp_val_wr = 1; tick(); check_all("R5 cmp value write");
        cap_val_rd = 1; tick(); check_all("R5 capture read");
        cmp_evt = 1; cmp_val_wr = 1; cap_evt = 1; stat_clr_en = 1; stat_clr_data = 2'b11;
        tick(); check_all("R6 events vs clears");
        stat_set_en = 1; stat_set_data = 2'b10; cap_val_rd = 1; tick(); check_all("R6 set vs side clear");
        mask_clr_en = 1; mask_clr_data = 2'b10; tick(); check_all("R7 mask clear bit1");
        mask_wr_en = 1; mask_wr_data = 2'b10; tick(); check_all("R7 mask write");
        mask_set_en = 1; mask_set_data = 2'b01; mask_clr_en = 1; mask_clr_data = 2'b11;
        tick(); check_all("R8 set over clear");
        mask_clr_en = 1; mask_clr_data = 2'b01; mask_wr_en = 1; mask_wr_data = 2'b11;
        tick(); check_all("R8 clear over write");
        repeat (3) begin tick(); check_all("R10 hold"); end

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cmp_evt = r[0] & r[1] & r[2]; cap_evt = r[3] & r[4] & r[5];
            stat_set_en = r[6] & r[7]; stat_set_data = r[9:8];
            stat_clr_en = r[10]; stat_clr_data = r[12:11];
            mask_wr_en = r[13] & r[14]; mask_wr_data = r[16:15];
            mask_set_en = r[17] & r[18]; mask_set_data = r[20:19];
            mask_clr_en = r[21]; mask_clr_data = r[23:22];
            cmp_val_wr = r[24] & r[25]; cap_val_rd = r[26] & r[27];
            if (r[31:29] == 3'b000) idle();
            tick();
            check_all("R10 sweep");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule